// File: doc/BRIEF.md
# SMBus transaction sequencer

This block sits in front of an I2C master engine that consumes a queue of command entries. Each entry holds one data byte plus three flags: read, stop and restart. The sequencer accepts one transaction request and turns it into the ordered list of entries that the engine needs. A request carries a command byte, a write count, a read count and three options: skip the command byte, skip the count handling, and leave the bus open at the end. While it runs, the block pulls write bytes from a streaming input, pushes received bytes to a streaming output and finishes with a one-cycle done pulse. The pulse comes with an error indication, the number of bytes delivered and a flag that reports discarded leftover receive data.

Three rules govern where the flags go. The first entry of a transaction always opens with a restart. The stop lands on the final entry that the request implies. Reads are pipelined: one read entry is always queued ahead of the byte being waited on. In count mode (the count-skip option clear), a write sends the write count after the command byte. A read in count mode treats the first received byte as a length. That byte is not delivered, and it can shorten the read but never lengthen it. A silent engine is caught by a receive timeout. An abort signal from the engine ends the transaction at once.

Top module: `smb_txn_sequencer`

## Requirements
- R1: After reset the block is idle: req_ready is 1 and q_valid, rd_valid and done are 0.
- R2: When no-command is clear, the first entry is the command byte with restart set and read clear. When no-command is set, the first entry emitted (write or read) carries restart. Later write entries never carry restart.
- R3: The command entry carries stop exactly when both counts are zero and no-stop is clear.
- R4: With a nonzero write count and no-count clear, the entry after the command byte carries the low 8 bits of the write count as data, with stop clear.
- R5: Write bytes are forwarded in arrival order, and a byte is taken only in a cycle where q_ready is high. The last write byte carries stop only when the read count is zero and no-stop is clear.
- R6: The first read entry carries read and restart. It carries stop only when the read count is 1, no-count is set and no-stop is clear.
- R7: Before each wait for a receive byte with more than one byte remaining, one further read entry (restart clear) is queued. That entry carries stop exactly when two bytes remain and no-count is in effect, whatever the no-stop setting.
- R8: With no-count clear, the first received byte is a length and is not delivered. The remaining count becomes the smaller of the requested count and that length, and a length of 0 ends the transaction.
- R9: Received data bytes appear on rd_data in order under a valid/ready handshake. At done, actual_count equals the number of bytes delivered.
- R10: Receive bytes already waiting when a request is accepted are consumed and never delivered, and stale_flag is 1 at done.
- R11: If no receive byte arrives within TIMEOUT_CYCLES cycles of waiting, the transaction ends with error. A byte that arrives in the last cycle of the window is taken instead.
- R12: engine_abort during an active transaction ends it with done and error, and no further entries are emitted.
- R13: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transaction request valid |
| req_ready | output | 1 | Ready for a new request (idle) |
| req_cmd | input | 8 | Command byte |
| req_wcount | input | CW | Number of write bytes |
| req_rcount | input | CW | Number of read bytes requested |
| req_no_cmd | input | 1 | Skip the command byte |
| req_no_count | input | 1 | Skip write count byte and read length byte |
| req_no_stop | input | 1 | Leave the bus open at the end |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| q_valid | output | 1 | Command entry valid |
| q_ready | input | 1 | Engine queue has room |
| q_data | output | 8 | Entry data byte (0 for reads) |
| q_read | output | 1 | Entry requests a read |
| q_stop | output | 1 | Entry ends with stop |
| q_restart | output | 1 | Entry begins with (re)start |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Received byte taken |
| rx_data | input | 8 | Received byte |
| engine_abort | input | 1 | Engine reports an abort |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte consumer ready |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| error | output | 1 | Transaction ended by timeout or abort |
| actual_count | output | CW | Bytes delivered in the last transaction |
| stale_flag | output | 1 | Leftover receive data was discarded |

## Verification
The receive timeout and the arrival of a receive byte can land in the same cycle: the last cycle of the wait window. The bench provokes this by holding back the engine's reply by a programmed number of cycles after the read entry is accepted. At one cycle inside the limit the byte must be delivered with no error. At one cycle beyond it the transaction must end with error and nothing delivered. A second overlap, a length of zero in count mode leaving an already-requested byte behind, is judged on the next transaction: that byte must be swallowed and reported as stale.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FLUSH, S_CMD, S_WCNT, S_WDATA,
    S_RFIRST, S_RAHEAD, S_RWAIT, S_ROUT, S_DONE
  } seq_state_t;

  typedef struct packed {
    logic       rd;
    logic       stop;
    logic       restart;
    logic [7:0] data;
  } q_entry_t;
endpackage

// File: rtl/smbseq_entry_gen.sv
module smbseq_entry_gen
  import smbseq_pkg::*;
#(
  parameter int CW = 8
) (
  input  seq_state_t    state,
  input  logic [7:0]    cmd_byte,
  input  logic [CW-1:0] wcount_req,
  input  logic [CW-1:0] rcount_req,
  input  logic [CW-1:0] wrem,
  input  logic [CW-1:0] rrem,
  input  logic          nocnt_now,
  input  logic          nostop,
  input  logic          first,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          ent_valid,
  output q_entry_t      ent
);
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);

  always_comb begin
    ent_valid = 1'b0;
    ent       = '0;
    unique case (state)
      S_CMD: begin
        ent_valid   = 1'b1;
        ent.restart = 1'b1;
        ent.data    = cmd_byte;
        ent.stop    = (wcount_req == ZERO) && (rcount_req == ZERO) && !nostop;
      end
      S_WCNT: begin
        ent_valid   = 1'b1;
        ent.restart = first;
        ent.data    = 8'(wcount_req);
      end
      S_WDATA: begin
        ent_valid   = wr_valid;
        ent.restart = first;
        ent.data    = wr_data;
        ent.stop    = (wrem == ONE) && (rcount_req == ZERO) && !nostop;
      end
      S_RFIRST: begin
        ent_valid   = 1'b1;
        ent.rd      = 1'b1;
        ent.restart = 1'b1;
        ent.stop    = (rcount_req == ONE) && nocnt_now && !nostop;
      end
      S_RAHEAD: begin
        ent_valid = (rrem > ONE);
        ent.rd    = 1'b1;
        ent.stop  = nocnt_now && (rrem == TWO);
      end
      default: begin
        ent_valid = 1'b0;
        ent       = '0;
      end
    endcase
  end
endmodule

// File: rtl/smbseq_rx_timer.sv
module smbseq_rx_timer #(
  parameter int TIMEOUT_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hit,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || hit) cnt <= '0;
    else if (cnt != LAST)   cnt <= cnt + TW'(1);
  end

  assign expired = run && (cnt == LAST);

  // R11
  window_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= LAST));
endmodule

// File: rtl/smb_txn_sequencer.sv
module smb_txn_sequencer
  import smbseq_pkg::*;
#(
  parameter int CW             = 8,
  parameter int TIMEOUT_CYCLES = 1250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [7:0]    req_cmd,
  input  logic [CW-1:0] req_wcount,
  input  logic [CW-1:0] req_rcount,
  input  logic          req_no_cmd,
  input  logic          req_no_count,
  input  logic          req_no_stop,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  output logic          q_valid,
  input  logic          q_ready,
  output logic [7:0]    q_data,
  output logic          q_read,
  output logic          q_stop,
  output logic          q_restart,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          engine_abort,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [7:0]    rd_data,
  output logic          done,
  output logic          error,
  output logic [CW-1:0] actual_count,
  output logic          stale_flag
);
  localparam int XW = CW + 8;
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  seq_state_t    state;
  seq_state_t    after_cmd;
  logic [7:0]    cmd_r;
  logic [CW-1:0] wcount_r, rcount_r, wrem, rrem;
  logic          nocmd_r, nocnt_r, nostop_r, first_r;
  logic [7:0]    rdata_r;
  logic [CW-1:0] actual_r;
  logic          stale_r, err_r;
  logic          tmo;
  logic [CW-1:0] clamp;
  q_entry_t      ent;
  logic          ent_valid;

  smbseq_entry_gen #(.CW(CW)) u_entry (
    .state      (state),
    .cmd_byte   (cmd_r),
    .wcount_req (wcount_r),
    .rcount_req (rcount_r),
    .wrem       (wrem),
    .rrem       (rrem),
    .nocnt_now  (nocnt_r),
    .nostop     (nostop_r),
    .first      (first_r),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .ent_valid  (ent_valid),
    .ent        (ent)
  );

  smbseq_rx_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == S_RWAIT),
    .hit     (rx_valid),
    .expired (tmo)
  );

  always_comb begin
    if (wcount_r != ZERO)      after_cmd = nocnt_r ? S_WDATA : S_WCNT;
    else if (rcount_r != ZERO) after_cmd = S_RFIRST;
    else                       after_cmd = S_DONE;
  end

  always_comb begin
    logic [XW-1:0] rx_ext, rem_ext;
    rx_ext  = XW'(rx_data);
    rem_ext = XW'(rrem);
    clamp   = (rx_ext < rem_ext) ? CW'(rx_data) : rrem;
  end

  assign req_ready    = (state == S_IDLE);
  assign q_valid      = ent_valid;
  assign q_data       = ent.data;
  assign q_read       = ent.rd;
  assign q_stop       = ent.stop;
  assign q_restart    = ent.restart;
  assign wr_ready     = (state == S_WDATA) && q_ready;
  assign rx_ready     = (state == S_FLUSH) || (state == S_RWAIT);
  assign rd_valid     = (state == S_ROUT);
  assign rd_data      = rdata_r;
  assign done         = (state == S_DONE);
  assign error        = err_r;
  assign actual_count = actual_r;
  assign stale_flag   = stale_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cmd_r    <= '0;
      wcount_r <= '0;
      rcount_r <= '0;
      wrem     <= '0;
      rrem     <= '0;
      nocmd_r  <= 1'b0;
      nocnt_r  <= 1'b0;
      nostop_r <= 1'b0;
      first_r  <= 1'b0;
      rdata_r  <= '0;
      actual_r <= '0;
      stale_r  <= 1'b0;
      err_r    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          cmd_r    <= req_cmd;
          wcount_r <= req_wcount;
          rcount_r <= req_rcount;
          wrem     <= req_wcount;
          rrem     <= req_rcount;
          nocmd_r  <= req_no_cmd;
          nocnt_r  <= req_no_count;
          nostop_r <= req_no_stop;
          first_r  <= 1'b1;
          actual_r <= '0;
          stale_r  <= 1'b0;
          err_r    <= 1'b0;
          state    <= S_FLUSH;
        end
        S_FLUSH: begin
          if (rx_valid) stale_r <= 1'b1;
          else          state   <= nocmd_r ? after_cmd : S_CMD;
        end
        S_CMD: if (q_ready) begin
          first_r <= 1'b0;
          state   <= after_cmd;
        end
        S_WCNT: if (q_ready) begin
          first_r <= 1'b0;
          state   <= S_WDATA;
        end
        S_WDATA: if (wr_valid && q_ready) begin
          first_r <= 1'b0;
          wrem    <= wrem - ONE;
          if (wrem == ONE) state <= (rcount_r != ZERO) ? S_RFIRST : S_DONE;
        end
        S_RFIRST: if (q_ready) state <= S_RAHEAD;
        S_RAHEAD: if (rrem <= ONE || q_ready) state <= S_RWAIT;
        S_RWAIT: begin
          if (rx_valid) begin
            if (nocnt_r) begin
              rdata_r <= rx_data;
              state   <= S_ROUT;
            end else begin
              rrem    <= clamp;
              nocnt_r <= 1'b1;
              state   <= (clamp == ZERO) ? S_DONE : S_RAHEAD;
            end
          end else if (tmo) begin
            err_r <= 1'b1;
            state <= S_DONE;
          end
        end
        S_ROUT: if (rd_ready) begin
          rrem     <= rrem - ONE;
          actual_r <= actual_r + ONE;
          state    <= (rrem == ONE) ? S_DONE : S_RAHEAD;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (engine_abort && state != S_IDLE && state != S_DONE) begin
        err_r <= 1'b1;
        state <= S_DONE;
      end
    end
  end

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R5
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |-> (q_valid && q_ready && !q_read && q_data == wr_data));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!q_valid && !rd_valid && !rx_ready));

  // R9
  done_count_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (actual_count <= rcount_r));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready));
endmodule

// File: tb/test_smb_txn_sequencer.sv
module test_smb_txn_sequencer;
  localparam int CW = 8;
  localparam int TO = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [7:0]    req_cmd = '0;
  logic [CW-1:0] req_wcount = '0;
  logic [CW-1:0] req_rcount = '0;
  logic          req_no_cmd = 1'b0;
  logic          req_no_count = 1'b0;
  logic          req_no_stop = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_data = '0;
  logic          q_valid;
  logic          q_ready = 1'b1;
  logic [7:0]    q_data;
  logic          q_read, q_stop, q_restart;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [7:0]    rx_data = '0;
  logic          engine_abort = 1'b0;
  logic          rd_valid;
  logic          rd_ready = 1'b1;
  logic [7:0]    rd_data;
  logic          done, error, stale_flag;
  logic [CW-1:0] actual_count;

  always #10 clk = ~clk;

  smb_txn_sequencer #(.CW(CW), .TIMEOUT_CYCLES(TO)) i_smb_txn_sequencer (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_wcount(req_wcount), .req_rcount(req_rcount),
    .req_no_cmd(req_no_cmd), .req_no_count(req_no_count), .req_no_stop(req_no_stop),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data),
    .q_read(q_read), .q_stop(q_stop), .q_restart(q_restart),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .engine_abort(engine_abort),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .error(error), .actual_count(actual_count), .stale_flag(stale_flag)
  );

  int checks = 0;
  int errors = 0;

  logic [10:0] exp_ent[$];
  string       exp_tag[$];
  logic [7:0]  exp_rd[$];
  logic [7:0]  wr_src[$];
  logic [7:0]  resp_src[$];
  logic [7:0]  rx_pend[$];
  int          lat_set = 0;
  int          lat_ctr = 0;
  bit          throttle = 0;
  bit          rd_throttle = 0;
  bit          exp_err = 0;
  bit          exp_stale = 0;
  int          exp_actual = 0;
  string       err_tag = "R9";
  string       rd_tag = "R9";
  int          done_cnt = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive then observe, away from the rising edge
  always begin
    @(negedge clk);
    q_ready  = throttle ? ($urandom_range(0, 2) != 0) : 1'b1;
    rd_ready = rd_throttle ? ($urandom_range(0, 1) != 0) : 1'b1;
    if (lat_ctr > 0) lat_ctr--;
    rx_valid = (rx_pend.size() > 0) && (lat_ctr == 0);
    rx_data  = (rx_pend.size() > 0) ? rx_pend[0] : 8'h00;
    wr_valid = (wr_src.size() > 0);
    wr_data  = (wr_src.size() > 0) ? wr_src[0] : 8'h00;
    #2;
    if (!rst) begin
      if (q_valid && q_ready) begin
        logic [10:0] got;
        got = {q_read, q_stop, q_restart, q_data};
        if (exp_ent.size() == 0) chk(1'b0, "R2", "unexpected entry", int'(got), 0);
        else begin
          logic [10:0] e;
          string t;
          e = exp_ent.pop_front();
          t = exp_tag.pop_front();
          chk(got == e, t, "entry {rd,stop,restart,data}", int'(got), int'(e));
        end
        if (q_read && resp_src.size() > 0) begin
          rx_pend.push_back(resp_src.pop_front());
          lat_ctr = lat_set;
        end
      end
      if (wr_valid && !q_ready) chk(!wr_ready, "R5", "write taken while queue full", int'(wr_ready), 0);
      if (wr_valid && wr_ready) void'(wr_src.pop_front());
      if (rx_valid && rx_ready) void'(rx_pend.pop_front());
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) chk(1'b0, rd_tag, "unexpected read byte", int'(rd_data), 0);
        else begin
          logic [7:0] b;
          b = exp_rd.pop_front();
          chk(rd_data == b, rd_tag, "read byte", int'(rd_data), int'(b));
        end
      end
      if (done) begin
        chk(error == exp_err, err_tag, "error at done", int'(error), int'(exp_err));
        chk(int'(actual_count) == exp_actual, "R9", "actual_count", int'(actual_count), exp_actual);
        chk(stale_flag == exp_stale, "R10", "stale_flag", int'(stale_flag), int'(exp_stale));
        chk(exp_ent.size() == 0, "R2", "entries left unsent", exp_ent.size(), 0);
        chk(exp_rd.size() == 0, rd_tag, "read bytes left undelivered", exp_rd.size(), 0);
        done_cnt++;
      end
    end
  end

  task automatic run_txn(input logic [7:0] cmd, input int w, input int r,
                         input bit ncmd, input bit ncnt, input bit nstop,
                         input bit e_err, input bit e_stale, input bit tmo,
                         input int abort_keep);
    logic [7:0] wq[$];
    logic [7:0] rq[$];
    bit first, nc;
    int rem, idx, act, start, n;
    wq = wr_src;
    rq = resp_src;
    first = ncmd;
    act = 0;
    if (!ncmd) begin
      exp_ent.push_back({1'b0, (w == 0 && r == 0 && !nstop), 1'b1, cmd});
      exp_tag.push_back("R3");
    end
    if (w != 0 && !ncnt) begin
      exp_ent.push_back({1'b0, 1'b0, first, 8'(w)});
      exp_tag.push_back("R4");
      first = 0;
    end
    for (int i = 0; i < w && i < wq.size(); i++) begin
      exp_ent.push_back({1'b0, (i == w - 1 && r == 0 && !nstop), first, wq[i]});
      exp_tag.push_back(first ? "R2" : "R5");
      first = 0;
    end
    if (r != 0) begin
      exp_ent.push_back({1'b1, (r == 1 && ncnt && !nstop), 1'b1, 8'h00});
      exp_tag.push_back("R6");
    end
    rem = r; nc = ncnt; idx = 0;
    while (rem > 0 && idx < rq.size()) begin
      logic [7:0] b;
      if (rem > 1) begin
        exp_ent.push_back({1'b1, (nc && rem == 2), 1'b0, 8'h00});
        exp_tag.push_back("R7");
      end
      b = rq[idx++];
      if (nc) begin exp_rd.push_back(b); rem--; act++; end
      else begin rem = (int'(b) < rem) ? int'(b) : rem; nc = 1; end
    end
    if (tmo) begin exp_rd.delete(); act = 0; end
    if (abort_keep >= 0) begin
      while (exp_ent.size() > abort_keep) begin
        void'(exp_ent.pop_back());
        void'(exp_tag.pop_back());
      end
    end
    exp_err = e_err; exp_stale = e_stale; exp_actual = act;
    start = done_cnt;
    @(negedge clk);
    req_cmd = cmd; req_wcount = CW'(w); req_rcount = CW'(r);
    req_no_cmd = ncmd; req_no_count = ncnt; req_no_stop = nstop;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (abort_keep >= 0) begin
      repeat (12) @(negedge clk);
      engine_abort = 1'b1;
      @(negedge clk);
      engine_abort = 1'b0;
    end
    n = 0;
    while (done_cnt == start && n < 4000) begin @(negedge clk); n++; end
    chk(done_cnt > start, "R9", "done reached", done_cnt - start, 1);
    @(negedge clk);
    if (tmo) begin
      #3;
      rx_pend.delete();
      lat_ctr = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #3;
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(q_valid == 1'b0, "R1", "q_valid after reset", int'(q_valid), 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);

    // R3: command only, with and without stop
    run_txn(8'h11, 0, 0, 0, 1, 0, 0, 0, 0, -1);
    run_txn(8'h12, 0, 0, 0, 1, 1, 0, 0, 0, -1);
    // R5: single write byte, stop on it
    wr_src = '{8'hA5};
    run_txn(8'h20, 1, 0, 0, 1, 0, 0, 0, 0, -1);
    // R4 R5: counted write under queue back-pressure
    throttle = 1;
    wr_src = '{8'h01, 8'h02, 8'h03};
    run_txn(8'h30, 3, 0, 0, 0, 0, 0, 0, 0, -1);
    throttle = 0;
    // R6 R7 R9: word read, low byte then high byte, consumer stalls (R13)
    rd_throttle = 1;
    resp_src = '{8'h34, 8'h12};
    run_txn(8'h40, 0, 2, 0, 1, 0, 0, 0, 0, -1);
    rd_throttle = 0;
    // R5 R6 R7: write word then read word
    wr_src = '{8'hCD, 8'hAB};
    resp_src = '{8'h78, 8'h56};
    run_txn(8'h50, 2, 2, 0, 1, 0, 0, 0, 0, -1);
    // R6: single byte read carries stop on the first read entry
    resp_src = '{8'h9E};
    run_txn(8'h60, 0, 1, 0, 1, 0, 0, 0, 0, -1);
    // R7: read-ahead stop at two remaining despite no-stop
    resp_src = '{8'h01, 8'h02, 8'h03};
    run_txn(8'h61, 0, 3, 0, 1, 1, 0, 0, 0, -1);
    // R8: length byte 3 shortens a request of 5
    rd_tag = "R8";
    throttle = 1;
    resp_src = '{8'h03, 8'hB1, 8'hB2, 8'hB3};
    run_txn(8'h70, 0, 5, 0, 0, 0, 0, 0, 0, -1);
    throttle = 0;
    // R8: length byte 9 does not lengthen a request of 2
    resp_src = '{8'h09, 8'hC1, 8'hC2};
    run_txn(8'h71, 0, 2, 0, 0, 0, 0, 0, 0, -1);
    // R8: length byte 0 ends at once, leaving one requested byte behind
    resp_src = '{8'h00, 8'hEE};
    run_txn(8'h72, 0, 3, 0, 0, 0, 0, 0, 0, -1);
    rd_tag = "R9";
    // R10 R2: leftover byte swallowed; no-command write opens with restart
    wr_src = '{8'h5A, 8'h5B};
    run_txn(8'h00, 2, 0, 1, 1, 0, 0, 1, 0, -1);
    // R10 R2: preloaded stale bytes; no-command read with no-stop
    rx_pend = '{8'hF0, 8'hF1};
    resp_src = '{8'h44};
    run_txn(8'h00, 0, 1, 1, 1, 1, 0, 1, 0, -1);
    // R11: reply in the last cycle of the window is taken
    err_tag = "R11";
    lat_set = TO + 1;
    resp_src = '{8'h3C};
    run_txn(8'h80, 0, 1, 0, 1, 0, 0, 0, 0, -1);
    // R11: reply one cycle late ends with error
    lat_set = TO + 2;
    resp_src = '{8'h3D};
    run_txn(8'h81, 0, 1, 0, 1, 0, 1, 0, 1, -1);
    lat_set = 0;
    // R12: abort while waiting for write data
    err_tag = "R12";
    run_txn(8'h90, 2, 0, 0, 1, 0, 1, 0, 0, 1);
    err_tag = "R9";
    // after abort: a normal transaction still works
    resp_src = '{8'h21};
    run_txn(8'h91, 0, 1, 0, 1, 0, 0, 0, 0, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule